// File: doc/BRIEF.md
# Write Protection Register Controller

This block keeps the write-protection state of a serial word-organised non-volatile memory. It holds a boundary address, a protection flag and a one-time lock bit. It acts on decoded instruction strobes that a serial front end hands over, together with the protection-enable pin level, the write-protect pin level and the state of the write-enable latch. Every location from the boundary address up to the top of the array refuses writes while the flag is 0.

The same front end asks the block whether a pending single-word, page or whole-array write may be committed. It also takes the frame it shifts out for a protection-register read from here. Changes to the register must be authorised by the instruction that came immediately before them. After the lock instruction the register is frozen for good, and the front end stops presenting busy/ready status.

Top module: `wp_ctrl`

## Requirements
- R1: After reset the boundary is all ones, the flag is 1 and the lock bit is clear. `status_vis` is 1, and a single write to the top address is allowed when `w_pin` and `wel` are high.
- R2: With `pre_pin` high, opcode 01 stores `ins_addr` as the boundary and sets the flag to 0, provided it is authorised.
- R3: With `pre_pin` high, opcode 11 with an all-ones address sets the boundary to all ones and the flag to 1, provided it is authorised.
- R4: A register change (R2, R3, R5) needs `pre_pin` and `w_pin` high. It also needs the instruction just before it to have been an arm instruction: opcode 00 with the top two address bits 11, accepted only with `pre_pin`, `w_pin` and `wel` all high. Any other strobe in between cancels the authorisation.
- R5: With `pre_pin` high, opcode 00 with an all-zero address sets the lock bit, provided it is authorised. Once set, `status_vis` stays 0 and the boundary and flag never change again.
- R6: `prot_frame` carries, MSB first, a dummy 0, then the boundary bits MSB first, then the flag in bit 0.
- R7: A single write (`chk_kind` = 1) is allowed when the flag is 1 or `chk_addr` is below the boundary.
- R8: A page write (`chk_kind` = 2) of `chk_words` words covers `chk_addr` with its two low bits stepping and wrapping inside the 4-word page. It is rejected as a whole if any covered word is protected.
- R9: A whole-array write (`chk_kind` = 3) is allowed only when the flag is 1.
- R10: `wr_ok` is 0 whenever `w_pin` or `wel` is low, or when `chk_kind` is 0.
- R11: The arm instruction leaves the boundary and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ins_vld | input | 1 | One-cycle strobe: a decoded instruction is present |
| ins_op | input | 2 | Opcode of the instruction |
| ins_addr | input | 8 | Address field of the instruction |
| pre_pin | input | 1 | Protection-register enable pin level |
| w_pin | input | 1 | Write-protect pin level (high permits writes) |
| wel | input | 1 | Write-enable latch state |
| chk_kind | input | 2 | Write query: 0 none, 1 single, 2 page, 3 whole array |
| chk_addr | input | 8 | Address of the queried write (first word for a page) |
| chk_words | input | 3 | Number of words in a page write, 1 to 4 |
| wr_ok | output | 1 | The queried write may be committed |
| prot_frame | output | 10 | Protection-register read frame |
| status_vis | output | 1 | Busy/ready status may be presented (lock clear) |

## Verification
Register changes take effect at the clock edge that samples the strobe. `prot_frame` and `status_vis` are therefore due one cycle after the strobe is driven. `wr_ok` is combinational from the query inputs and the current register state, so it is valid in the same cycle the query is applied. The driver applies each stimulus on the falling edge and queues its expectation just after the next rising edge. The monitor compares a quarter period later, once that edge's register update has settled and before the driver touches any input again.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        OP_MISC = 2'b00,
        OP_SET  = 2'b01,
        OP_READ = 2'b10,
        OP_WIPE = 2'b11
    } wp_op_e;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_ONE  = 2'd1,
        CK_PAGE = 2'd2,
        CK_ALL  = 2'd3
    } wp_kind_e;

    typedef struct packed {
        logic arm;
        logic set_bnd;
        logic wipe;
        logic lock;
    } wp_act_t;

endpackage

// File: rtl/wp_decode.sv
module wp_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              ins_vld,
    input  logic [1:0]        ins_op,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              pre_pin,
    input  logic              w_pin,
    input  logic              wel,
    output wp_act_t           act
);

    logic sel;

    always_comb begin
        sel         = ins_vld & pre_pin & w_pin;
        act.arm     = sel & wel & (ins_op == OP_MISC)
                      & (ins_addr[ADDR_W-1 -: 2] == 2'b11);
        act.set_bnd = sel & (ins_op == OP_SET);
        act.wipe    = sel & (ins_op == OP_WIPE) & (&ins_addr);
        act.lock    = sel & (ins_op == OP_MISC) & (ins_addr == '0);
    end

endmodule

// File: rtl/wp_regs.sv
module wp_regs
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_vld,
    input  logic [ADDR_W-1:0] ins_addr,
    input  wp_act_t           act,
    output logic [ADDR_W-1:0] bnd,
    output logic              flag,
    output logic              otp
);

    typedef struct packed {
        logic [ADDR_W-1:0] bnd;
        logic              flag;
        logic              otp;
        logic              armed;
    } st_t;

    st_t st_d, st_q;
    logic go;

    always_comb begin
        st_d = st_q;
        go   = st_q.armed & ~st_q.otp;
        if (ins_vld) begin
            st_d.armed = act.arm;
        end
        if (go) begin
            if (act.set_bnd) begin
                st_d.bnd  = ins_addr;
                st_d.flag = 1'b0;
            end else if (act.wipe) begin
                st_d.bnd  = '1;
                st_d.flag = 1'b1;
            end else if (act.lock) begin
                st_d.otp  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bnd: '1, flag: 1'b1, otp: 1'b0, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bnd  = st_q.bnd;
    assign flag = st_q.flag;
    assign otp  = st_q.otp;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_WORDS = 4,
    localparam int PG_BITS   = $clog2(PAGE_WORDS),
    localparam int CNT_W     = $clog2(PAGE_WORDS + 1)
) (
    input  logic [ADDR_W-1:0] bnd,
    input  logic              flag,
    input  logic [1:0]        chk_kind,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [CNT_W-1:0]  chk_words,
    input  logic              w_pin,
    input  logic              wel,
    output logic              wr_ok
);

    logic [PAGE_WORDS-1:0] hit;
    logic                  one_prot;

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
        logic [ADDR_W-1:0] waddr;
        always_comb begin
            waddr  = {chk_addr[ADDR_W-1:PG_BITS],
                      chk_addr[PG_BITS-1:0] + PG_BITS'(i)};
            hit[i] = (CNT_W'(i) < chk_words) & ~flag & (waddr >= bnd);
        end
    end

    always_comb begin
        one_prot = ~flag & (chk_addr >= bnd);
        wr_ok    = 1'b0;
        if (w_pin & wel) begin
            case (chk_kind)
                CK_ONE:  wr_ok = ~one_prot;
                CK_PAGE: wr_ok = (hit == '0) & (chk_words != '0);
                CK_ALL:  wr_ok = flag;
                default: wr_ok = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_WORDS = 4,
    localparam int CNT_W     = $clog2(PAGE_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_vld,
    input  logic [1:0]        ins_op,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              pre_pin,
    input  logic              w_pin,
    input  logic              wel,
    input  logic [1:0]        chk_kind,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [CNT_W-1:0]  chk_words,
    output logic              wr_ok,
    output logic [ADDR_W+1:0] prot_frame,
    output logic              status_vis
);

    wp_act_t           act;
    logic [ADDR_W-1:0] bnd;
    logic              flag;
    logic              otp;

    wp_decode #(.ADDR_W(ADDR_W)) u_dec (
        .ins_vld  (ins_vld),
        .ins_op   (ins_op),
        .ins_addr (ins_addr),
        .pre_pin  (pre_pin),
        .w_pin    (w_pin),
        .wel      (wel),
        .act      (act)
    );

    wp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_vld  (ins_vld),
        .ins_addr (ins_addr),
        .act      (act),
        .bnd      (bnd),
        .flag     (flag),
        .otp      (otp)
    );

    wp_guard #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_guard (
        .bnd       (bnd),
        .flag      (flag),
        .chk_kind  (chk_kind),
        .chk_addr  (chk_addr),
        .chk_words (chk_words),
        .w_pin     (w_pin),
        .wel       (wel),
        .wr_ok     (wr_ok)
    );

    assign prot_frame = {1'b0, bnd, flag};
    assign status_vis = ~otp;

endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_vld,
    input logic [1:0]        ins_op,
    input logic              pre_pin,
    input logic              w_pin,
    input logic [1:0]        chk_kind,
    input logic              wr_ok,
    input logic [ADDR_W+1:0] prot_frame,
    input logic              status_vis
);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_vis |=> !status_vis); // R5

    AST_FROZEN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !status_vis |=> $stable(prot_frame)); // R5

    AST_NO_PRE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && !pre_pin) |=> $stable(prot_frame)); // R4

    AST_WP_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !w_pin |-> !wr_ok); // R10

    AST_ALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_kind == 2'd3 && wr_ok) |-> prot_frame[0]); // R9

    AST_FLAG_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_frame[0]) |-> $past(ins_vld && pre_pin && ins_op == 2'b01)); // R2

endmodule

bind wp_ctrl wp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/wp_ctrl_test.sv
`timescale 1ns/1ps
module wp_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_vld = 1'b0;
    logic [1:0] ins_op = 2'b00;
    logic [7:0] ins_addr = 8'h00;
    logic       pre_pin = 1'b0;
    logic       w_pin = 1'b0;
    logic       wel = 1'b0;
    logic [1:0] chk_kind = 2'd0;
    logic [7:0] chk_addr = 8'h00;
    logic [2:0] chk_words = 3'd1;
    logic       wr_ok;
    logic [9:0] prot_frame;
    logic       status_vis;

    always #10 clk = ~clk;

    wp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_op(ins_op),
        .ins_addr(ins_addr), .pre_pin(pre_pin), .w_pin(w_pin), .wel(wel),
        .chk_kind(chk_kind), .chk_addr(chk_addr), .chk_words(chk_words),
        .wr_ok(wr_ok), .prot_frame(prot_frame), .status_vis(status_vis)
    );

    typedef struct {
        int         kind;
        logic [9:0] val;
        string      tag;
    } item_t;

    item_t q[$];
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_bnd  = 8'hFF;
    logic       m_flag = 1'b1;
    logic       m_otp  = 1'b0;
    logic       m_arm  = 1'b0;

    task automatic push(int kind, logic [9:0] val, string tag);
        item_t it;
        it.kind = kind;
        it.val  = val;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic push_state(string tag);
        push(0, {1'b0, m_bnd, m_flag}, tag);
        push(2, {9'd0, ~m_otp}, tag);
    endtask

    task automatic ins(logic [1:0] op, logic [7:0] addr, logic pre, logic w,
                       logic we, string tag);
        @(negedge clk);
        ins_vld = 1'b1; ins_op = op; ins_addr = addr;
        pre_pin = pre; w_pin = w; wel = we;
        @(posedge clk);
        #1;
        ins_vld = 1'b0;
        if (m_arm && !m_otp && pre && w) begin
            if (op == 2'b01) begin m_bnd = addr; m_flag = 1'b0; end
            else if (op == 2'b11 && addr == 8'hFF) begin m_bnd = 8'hFF; m_flag = 1'b1; end
            else if (op == 2'b00 && addr == 8'h00) m_otp = 1'b1;
        end
        m_arm = pre && w && we && op == 2'b00 && addr[7:6] == 2'b11;
        push_state(tag);
    endtask

    task automatic query(logic [1:0] kind, logic [7:0] addr, logic [2:0] words,
                         logic w, logic we, logic exp, string tag);
        @(negedge clk);
        chk_kind = kind; chk_addr = addr; chk_words = words;
        w_pin = w; wel = we;
        @(posedge clk);
        #1;
        push(1, {9'd0, exp}, tag);
    endtask

    // monitor: compares a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                item_t it;
                logic [9:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = prot_frame;
                    1:       act = {9'd0, wr_ok};
                    default: act = {9'd0, status_vis};
                endcase
                checks++;
                if (act !== it.val) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             it.tag, it.kind, act, it.val);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        push_state("R1 reset state / R6 frame");
        query(2'd1, 8'hFF, 3'd1, 1'b1, 1'b1, 1'b1, "R1 top address writable");

        ins(2'b01, 8'h82, 1'b1, 1'b1, 1'b1, "R4 write without arm ignored");
        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b1, "R11 arm keeps state");
        ins(2'b01, 8'h82, 1'b1, 1'b1, 1'b1, "R2 boundary written");

        query(2'd1, 8'h81, 3'd1, 1'b1, 1'b1, 1'b1, "R7 below boundary");
        query(2'd1, 8'h82, 3'd1, 1'b1, 1'b1, 1'b0, "R7 at boundary");
        query(2'd1, 8'hFF, 3'd1, 1'b1, 1'b1, 1'b0, "R7 top protected");
        query(2'd2, 8'h80, 3'd2, 1'b1, 1'b1, 1'b1, "R8 page below");
        query(2'd2, 8'h80, 3'd3, 1'b1, 1'b1, 1'b0, "R8 page third word hits");
        query(2'd2, 8'h83, 3'd2, 1'b1, 1'b1, 1'b0, "R8 page start protected");
        query(2'd2, 8'h7E, 3'd4, 1'b1, 1'b1, 1'b1, "R8 page wraps inside page");
        query(2'd3, 8'h00, 3'd1, 1'b1, 1'b1, 1'b0, "R9 write all while protected");
        query(2'd1, 8'h00, 3'd1, 1'b0, 1'b1, 1'b0, "R10 w pin low");
        query(2'd1, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0, "R10 latch low");
        query(2'd0, 8'h00, 3'd1, 1'b1, 1'b1, 1'b0, "R10 no query");

        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b1, "R11 arm");
        ins(2'b10, 8'h00, 1'b1, 1'b1, 1'b1, "R4 read between");
        ins(2'b11, 8'hFF, 1'b1, 1'b1, 1'b1, "R4 clear after read ignored");
        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b0, "R4 arm without latch");
        ins(2'b11, 8'hFF, 1'b1, 1'b1, 1'b1, "R4 clear unarmed ignored");
        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b1, "R4 arm");
        ins(2'b01, 8'h10, 1'b0, 1'b1, 1'b1, "R4 pre low cancels");
        ins(2'b11, 8'hFF, 1'b1, 1'b1, 1'b1, "R4 clear after cancel ignored");
        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b1, "R11 arm");
        ins(2'b11, 8'hFF, 1'b1, 1'b1, 1'b1, "R3 clear");
        query(2'd3, 8'h00, 3'd1, 1'b1, 1'b1, 1'b1, "R9 write all after clear");

        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b1, "R11 arm");
        ins(2'b01, 8'h40, 1'b1, 1'b1, 1'b1, "R2 boundary 40");
        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b1, "R11 arm");
        ins(2'b00, 8'h00, 1'b1, 1'b1, 1'b1, "R5 lock");
        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b1, "R5 arm after lock");
        ins(2'b11, 8'hFF, 1'b1, 1'b1, 1'b1, "R5 clear after lock ignored");
        ins(2'b00, 8'hC0, 1'b1, 1'b1, 1'b1, "R5 arm after lock");
        ins(2'b01, 8'h00, 1'b1, 1'b1, 1'b1, "R5 write after lock ignored");
        query(2'd1, 8'h40, 3'd1, 1'b1, 1'b1, 1'b0, "R5 R7 locked boundary holds");
        query(2'd1, 8'h3F, 3'd1, 1'b1, 1'b1, 1'b1, "R7 below locked boundary");

        repeat (2) @(posedge clk);
        #10;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule